// File: doc/BRIEF.md
# Delay-Slot-Aware Exception Entry Unit

This unit sits beside the execute stage of a 32-bit processor that has delayed branches. Each cycle it looks at the fault conditions raised for the instruction in execute: undefined opcode, privileged instruction, floating-point instruction, branch-class instruction, trap with an immediate, and a load or store with its size and low address bits. From the current PC, status word, stack register R15 and vector base, it builds every value the core has to commit when it enters an exception.

When a condition is present, the unit registers a complete entry record and raises a one-cycle strobe in the next cycle. The record holds the saved PC, saved status, saved stack pointer, event code, optional trap value, new status word, handler PC and the PC after it. The register file and control registers commit all of these on that strobe. When the faulting instruction sits in a branch delay slot, the unit picks the slot flavour of the event code. It also winds the saved PC back by one halfword so that it points at the branch, and it asks the pipeline to drop its delay-slot state.

Top module: `exc_entry_unit`

## Requirements
- R1: With `in_slot` low, the granted cause sets `expevt` to one of these codes: 0x180 for an undefined opcode, or for a privileged instruction while SR bit 30 (privileged mode) is 0. 0x800 for a floating-point instruction while SR bit 15 (FPU off) is 1. 0x0E0 for a misaligned read. 0x100 for a misaligned write. 0x160 for a trap.
- R2: With `in_slot` high, an undefined or privileged-in-user-mode instruction gives 0x1A0 and an FPU-off fault gives 0x820. A branch-class or trap instruction gives 0x1A0.
- R3: When several causes are present together, exactly one entry is taken. The order is: slot-illegal, then illegal/privilege, then FPU off, then read or write address error, then trap.
- R4: `mem_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A halfword access with address bit 0 set is misaligned, and so is a word access with either of address bits 1:0 set. A byte access is never misaligned. `mem_write` selects write over read.
- R5: `spc` is PC-2 (modulo 2^32) when `in_slot` is high, PC+2 for a trap outside a slot, and PC otherwise. `slot_clear` pulses together with `take_exc` exactly when `in_slot` was high.
- R6: `ssr` is the old SR and `sgr` is the old R15. `new_sr` is the old SR with bits 30, 29 and 28 forced to 1 and every other bit kept.
- R7: `new_pc` is VBR+0x100 and `next_pc` is VBR+0x102.
- R8: Only an entry caused by a trap pulses `tra_we`, and `tra` then holds the 8-bit immediate shifted left by 2. A trap that loses to a slot-illegal fault writes nothing.
- R9: `take_exc` is high in the cycle right after a cycle with any cause present, and low after a cycle with none. After a cycle with no cause, the entry values keep their previous contents.
- R10: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the instruction in execute |
| cur_sr | input | 32 | Current status register |
| cur_r15 | input | 32 | Current R15 |
| vbr | input | 32 | Vector base |
| in_slot | input | 1 | Instruction is in a branch delay slot |
| undef_op | input | 1 | Opcode is undefined |
| priv_op | input | 1 | Instruction needs privileged mode |
| fpu_op | input | 1 | Instruction uses the FPU |
| branch_op | input | 1 | Branch or branch-to-subroutine |
| trap_op | input | 1 | Trap instruction |
| trap_imm | input | 8 | Trap immediate |
| mem_op | input | 1 | Load or store present |
| mem_write | input | 1 | Access is a store |
| mem_size | input | 2 | Access size code |
| mem_addr_lo | input | 2 | Address bits 1:0 |
| take_exc | output | 1 | One-cycle entry strobe |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status |
| sgr | output | 32 | Saved R15 |
| expevt | output | 12 | Exception event code |
| tra_we | output | 1 | Trap value write strobe |
| tra | output | 32 | Trap value |
| new_sr | output | 32 | Status word for the handler |
| new_pc | output | 32 | Handler PC |
| next_pc | output | 32 | PC following the handler PC |
| slot_clear | output | 1 | Drop delay-slot state |

## Verification
An error in cause detection or arbitration appears in the cycle right after the request, as a wrong `expevt` code or as a strobe that is missing or extra. Faults in the slot handling show up in the same cycle. A slot flag that is lost inside the unit gives a normal code where the slot code belongs, and an `spc` that points one halfword too far forward. A state-update fault shows as a changed `spc` after a cycle with no request, and a trap-gating fault as a `tra_we` pulse on an entry that was not a trap.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam int NUM_CAUSE = 6;
  // Index order is the priority order: lower index wins.
  localparam int PRI_SLOT = 0;
  localparam int PRI_ILL  = 1;
  localparam int PRI_FPU  = 2;
  localparam int PRI_ARD  = 3;
  localparam int PRI_AWR  = 4;
  localparam int PRI_TRAP = 5;

  localparam logic [11:0] EV_ILLEGAL      = 12'h180;
  localparam logic [11:0] EV_SLOT_ILLEGAL = 12'h1A0;
  localparam logic [11:0] EV_FPU_OFF      = 12'h800;
  localparam logic [11:0] EV_SLOT_FPU_OFF = 12'h820;
  localparam logic [11:0] EV_ADDR_RD      = 12'h0E0;
  localparam logic [11:0] EV_ADDR_WR      = 12'h100;
  localparam logic [11:0] EV_TRAP         = 12'h160;

  typedef enum logic [1:0] {VK_GENERAL, VK_TLB_MISS, VK_EXT_IRQ} vec_kind_e;

  function automatic word_t handler_base(word_t base, vec_kind_e kind);
    case (kind)
      VK_TLB_MISS: return base + word_t'(32'h400);
      VK_EXT_IRQ:  return base + word_t'(32'h600);
      default:     return base + word_t'(32'h100);
    endcase
  endfunction

  function automatic logic misaligned(logic [1:0] size, logic [1:0] lo);
    case (size)
      2'd0:    return 1'b0;
      2'd1:    return lo[0];
      default: return |lo;
    endcase
  endfunction

  function automatic logic [11:0] event_code(logic [NUM_CAUSE-1:0] grant, logic slot);
    logic [11:0] c;
    c = 12'h000;
    if (grant[PRI_SLOT]) c = EV_SLOT_ILLEGAL;
    if (grant[PRI_ILL])  c = slot ? EV_SLOT_ILLEGAL : EV_ILLEGAL;
    if (grant[PRI_FPU])  c = slot ? EV_SLOT_FPU_OFF : EV_FPU_OFF;
    if (grant[PRI_ARD])  c = EV_ADDR_RD;
    if (grant[PRI_AWR])  c = EV_ADDR_WR;
    if (grant[PRI_TRAP]) c = EV_TRAP;
    return c;
  endfunction

  function automatic word_t resume_pc(word_t pc, logic slot, logic is_trap);
    if (slot)    return pc - word_t'(2);
    if (is_trap) return pc + word_t'(2);
    return pc;
  endfunction

  function automatic word_t force_bits(word_t sr, int a, int b, int c);
    word_t r;
    r = sr;
    r[a] = 1'b1;
    r[b] = 1'b1;
    r[c] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_cause_detect.sv
module exc_cause_detect
  import exc_entry_pkg::*;
#(
  parameter int MD_BIT = 30,
  parameter int FD_BIT = 15
) (
  input  word_t                 sr,
  input  logic                  in_slot,
  input  logic                  undef_op,
  input  logic                  priv_op,
  input  logic                  fpu_op,
  input  logic                  branch_op,
  input  logic                  trap_op,
  input  logic                  mem_op,
  input  logic                  mem_write,
  input  logic [1:0]            mem_size,
  input  logic [1:0]            mem_addr_lo,
  output logic [NUM_CAUSE-1:0]  cond
);
  logic user_mode;
  logic fpu_off;
  logic bad_align;

  always_comb begin
    user_mode = ~sr[MD_BIT];
    fpu_off   = sr[FD_BIT];
    bad_align = mem_op & misaligned(mem_size, mem_addr_lo);
    cond           = '0;
    cond[PRI_SLOT] = in_slot & (branch_op | trap_op);
    cond[PRI_ILL]  = undef_op | (priv_op & user_mode);
    cond[PRI_FPU]  = fpu_op & fpu_off;
    cond[PRI_ARD]  = bad_align & ~mem_write;
    cond[PRI_AWR]  = bad_align & mem_write;
    cond[PRI_TRAP] = trap_op & ~in_slot;
  end
endmodule

// File: rtl/exc_cause_arbiter.sv
module exc_cause_arbiter
  import exc_entry_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] cond,
  output logic [NUM_CAUSE-1:0] grant,
  output logic                 any_cause
);
  logic [NUM_CAUSE:0] seen;

  always_comb begin
    seen[0] = 1'b0;
    for (int k = 0; k < NUM_CAUSE; k++) begin
      grant[k]  = cond[k] & ~seen[k];
      seen[k+1] = seen[k] | cond[k];
    end
    any_cause = seen[NUM_CAUSE];
  end

  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_when_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond) == ($countones(grant) == 1));
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
#(
  parameter int MD_BIT     = 30,
  parameter int RB_BIT     = 29,
  parameter int BL_BIT     = 28,
  parameter int TRAP_IMM_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CAUSE-1:0]  grant,
  input  logic                  any_cause,
  input  logic                  in_slot,
  input  word_t                 pc,
  input  word_t                 sr,
  input  word_t                 r15,
  input  word_t                 vbr,
  input  logic [TRAP_IMM_W-1:0] trap_imm,
  output logic                  take_exc,
  output word_t                 spc,
  output word_t                 ssr,
  output word_t                 sgr,
  output logic [11:0]           expevt,
  output logic                  tra_we,
  output word_t                 tra,
  output word_t                 new_sr,
  output word_t                 new_pc,
  output word_t                 next_pc,
  output logic                  slot_clear
);
  word_t       base_d;
  logic [11:0] code_d;
  word_t       tra_d;

  always_comb begin
    base_d = handler_base(vbr, VK_GENERAL);
    code_d = event_code(grant, in_slot);
    tra_d  = word_t'(trap_imm) << 2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_exc   <= 1'b0;
      spc        <= '0;
      ssr        <= '0;
      sgr        <= '0;
      expevt     <= '0;
      tra_we     <= 1'b0;
      tra        <= '0;
      new_sr     <= '0;
      new_pc     <= '0;
      next_pc    <= '0;
      slot_clear <= 1'b0;
    end else begin
      take_exc   <= any_cause;
      slot_clear <= any_cause & in_slot;
      tra_we     <= grant[PRI_TRAP];
      if (any_cause) begin
        spc     <= resume_pc(pc, in_slot, grant[PRI_TRAP]);
        ssr     <= sr;
        sgr     <= r15;
        expevt  <= code_d;
        new_sr  <= force_bits(sr, MD_BIT, BL_BIT, RB_BIT);
        new_pc  <= base_d;
        next_pc <= base_d + word_t'(2);
      end
      if (grant[PRI_TRAP]) tra <= tra_d;
    end
  end

  p_strobe_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_cause |=> take_exc);
  p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cause |=> !take_exc && $stable(spc) && $stable(expevt));
  p_sr_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> new_sr[MD_BIT] && new_sr[BL_BIT] && new_sr[RB_BIT]);
  p_follow_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> next_pc == new_pc + word_t'(2));
  p_slot_wind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_cause && in_slot |=> slot_clear && spc == $past(pc) - word_t'(2));
  p_slot_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_clear |-> expevt != EV_ILLEGAL && expevt != EV_FPU_OFF && expevt != EV_TRAP);
  p_tra_only_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tra_we |-> take_exc && expevt == EV_TRAP && !slot_clear);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int MD_BIT     = 30,
  parameter int RB_BIT     = 29,
  parameter int BL_BIT     = 28,
  parameter int FD_BIT     = 15,
  parameter int TRAP_IMM_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           cur_pc,
  input  logic [31:0]           cur_sr,
  input  logic [31:0]           cur_r15,
  input  logic [31:0]           vbr,
  input  logic                  in_slot,
  input  logic                  undef_op,
  input  logic                  priv_op,
  input  logic                  fpu_op,
  input  logic                  branch_op,
  input  logic                  trap_op,
  input  logic [TRAP_IMM_W-1:0] trap_imm,
  input  logic                  mem_op,
  input  logic                  mem_write,
  input  logic [1:0]            mem_size,
  input  logic [1:0]            mem_addr_lo,
  output logic                  take_exc,
  output logic [31:0]           spc,
  output logic [31:0]           ssr,
  output logic [31:0]           sgr,
  output logic [11:0]           expevt,
  output logic                  tra_we,
  output logic [31:0]           tra,
  output logic [31:0]           new_sr,
  output logic [31:0]           new_pc,
  output logic [31:0]           next_pc,
  output logic                  slot_clear
);
  logic [NUM_CAUSE-1:0] cond;
  logic [NUM_CAUSE-1:0] grant;
  logic                 any_cause;

  exc_cause_detect #(.MD_BIT(MD_BIT), .FD_BIT(FD_BIT)) u_detect (
    .sr(cur_sr), .in_slot(in_slot), .undef_op(undef_op), .priv_op(priv_op),
    .fpu_op(fpu_op), .branch_op(branch_op), .trap_op(trap_op),
    .mem_op(mem_op), .mem_write(mem_write), .mem_size(mem_size),
    .mem_addr_lo(mem_addr_lo), .cond(cond)
  );

  exc_cause_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .cond(cond), .grant(grant), .any_cause(any_cause)
  );

  exc_entry_regs #(
    .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT), .TRAP_IMM_W(TRAP_IMM_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .grant(grant), .any_cause(any_cause),
    .in_slot(in_slot), .pc(cur_pc), .sr(cur_sr), .r15(cur_r15), .vbr(vbr),
    .trap_imm(trap_imm), .take_exc(take_exc), .spc(spc), .ssr(ssr), .sgr(sgr),
    .expevt(expevt), .tra_we(tra_we), .tra(tra), .new_sr(new_sr),
    .new_pc(new_pc), .next_pc(next_pc), .slot_clear(slot_clear)
  );

  p_trap_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_op && !in_slot && !undef_op && !(priv_op && !cur_sr[MD_BIT])
    && !(fpu_op && cur_sr[FD_BIT]) && !(mem_op && mem_size != 2'd0)
    |=> tra_we && spc == $past(cur_pc) + 32'd2);
endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] cur_pc, cur_sr, cur_r15, vbr;
  logic in_slot, undef_op, priv_op, fpu_op, branch_op, trap_op, mem_op, mem_write;
  logic [7:0] trap_imm;
  logic [1:0] mem_size, mem_addr_lo;
  logic take_exc, tra_we, slot_clear;
  logic [31:0] spc, ssr, sgr, tra, new_sr, new_pc, next_pc;
  logic [11:0] expevt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
    .vbr(vbr), .in_slot(in_slot), .undef_op(undef_op), .priv_op(priv_op),
    .fpu_op(fpu_op), .branch_op(branch_op), .trap_op(trap_op), .trap_imm(trap_imm),
    .mem_op(mem_op), .mem_write(mem_write), .mem_size(mem_size),
    .mem_addr_lo(mem_addr_lo), .take_exc(take_exc), .spc(spc), .ssr(ssr),
    .sgr(sgr), .expevt(expevt), .tra_we(tra_we), .tra(tra), .new_sr(new_sr),
    .new_pc(new_pc), .next_pc(next_pc), .slot_clear(slot_clear)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent model: returns code, 0 when nothing is raised.
  function automatic logic [11:0] model_code(logic slot, logic und, logic prv,
      logic fpu, logic br, logic trp, logic mem, logic wr, logic [1:0] sz,
      logic [1:0] lo, logic [31:0] sr);
    logic mis;
    mis = mem && ((sz == 2'd1 && lo[0]) || (sz >= 2'd2 && lo != 2'b00));
    if (slot && (br || trp)) return 12'h1A0;
    if (und || (prv && sr[30] == 1'b0)) return slot ? 12'h1A0 : 12'h180;
    if (fpu && sr[15]) return slot ? 12'h820 : 12'h800;
    if (mis) return wr ? 12'h100 : 12'h0E0;
    if (trp) return 12'h160;
    return 12'h000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev_spc;
    logic [11:0] code;
    logic [31:0] e_spc;
    cur_pc = 32'h1234_5678; cur_sr = 32'h0; cur_r15 = 32'h0; vbr = 32'h0;
    in_slot = 0; undef_op = 1; priv_op = 0; fpu_op = 0; branch_op = 0; trap_op = 0;
    trap_imm = 8'h0; mem_op = 0; mem_write = 0; mem_size = 2'd0; mem_addr_lo = 2'd0;
    repeat (3) @(negedge clk);
    // R10: outputs are zero under reset even with a request present
    chk("R10", "take_exc", 32'(take_exc), 32'd0);
    chk("R10", "spc", spc, 32'd0);
    chk("R10", "expevt", 32'(expevt), 32'd0);
    chk("R10", "new_pc", new_pc, 32'd0);
    chk("R10", "tra_we/slot_clear", {30'd0, tra_we, slot_clear}, 32'd0);
    undef_op = 0;
    rst_n = 1'b1;
    @(negedge clk);
    prev_spc = spc;

    // Sweep: cause flags, slot, mode bits, access size/write/address
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      v = 14'(i);
      undef_op = v[0]; priv_op = v[1]; fpu_op = v[2]; branch_op = v[3];
      trap_op = v[4]; mem_op = v[5]; in_slot = v[6]; mem_write = v[9];
      mem_size = v[11:10]; mem_addr_lo = v[13:12];
      cur_pc  = 32'h8C00_0000 + (32'(i) << 1);
      cur_sr  = ((32'hA5A5_3C3C ^ (32'(i) * 32'h0001_0003)) & ~32'h7000_8000)
                | (32'(v[7]) << 30) | (32'(v[8]) << 15);
      cur_r15 = ~cur_pc ^ 32'h0F0F_0000;
      vbr     = 32'h8000_0000 ^ (32'(i) << 8);
      trap_imm = v[7:0] ^ 8'h5A;
      code = model_code(in_slot, undef_op, priv_op, fpu_op, branch_op, trap_op,
                        mem_op, mem_write, mem_size, mem_addr_lo, cur_sr);
      if (in_slot) e_spc = cur_pc - 32'd2;
      else if (code == 12'h160) e_spc = cur_pc + 32'd2;
      else e_spc = cur_pc;
      @(negedge clk);
      if (code != 12'h000) begin
        chk("R9", "take_exc", 32'(take_exc), 32'd1);
        // R1 normal codes, R2 slot codes, R3 priority, R4 alignment
        chk(in_slot ? "R2" : "R1/R3/R4", "expevt", 32'(expevt), 32'(code));
        chk("R5", "spc", spc, e_spc);
        chk("R5", "slot_clear", 32'(slot_clear), 32'(in_slot));
        chk("R6", "ssr", ssr, cur_sr);
        chk("R6", "sgr", sgr, cur_r15);
        chk("R6", "new_sr", new_sr, cur_sr | 32'h7000_0000);
        chk("R7", "new_pc", new_pc, vbr + 32'h100);
        chk("R7", "next_pc", next_pc, vbr + 32'h102);
        chk("R8", "tra_we", 32'(tra_we), 32'(code == 12'h160));
        if (code == 12'h160) chk("R8", "tra", tra, 32'(trap_imm) * 4);
      end else begin
        chk("R9", "take_exc idle", 32'(take_exc), 32'd0);
        chk("R9", "spc held", spc, prev_spc);
        chk("R8", "tra_we idle", 32'(tra_we), 32'd0);
        chk("R5", "slot_clear idle", 32'(slot_clear), 32'd0);
      end
      prev_spc = spc;
    end

    // R5: slot wind-back wraps below address zero
    undef_op = 1; priv_op = 0; fpu_op = 0; branch_op = 0; trap_op = 0; mem_op = 0;
    in_slot = 1; cur_pc = 32'h0;
    @(negedge clk);
    chk("R5", "spc wrap", spc, 32'hFFFF_FFFE);
    chk("R2", "slot undefined", 32'(expevt), 32'h1A0);

    // R8: every trap immediate value
    undef_op = 0; in_slot = 0; trap_op = 1;
    for (int k = 0; k < 256; k++) begin
      trap_imm = 8'(k);
      cur_pc = 32'h0C00_0000 + 32'(k) * 2;
      @(negedge clk);
      chk("R8", "tra value", tra, 32'(k) << 2);
      chk("R5", "trap spc", spc, cur_pc + 32'd2);
    end
    // R8: trap losing to slot illegal leaves tra untouched
    in_slot = 1; trap_imm = 8'h11;
    @(negedge clk);
    chk("R8", "tra_we lost trap", 32'(tra_we), 32'd0);
    chk("R8", "tra kept", tra, 32'd255 << 2);
    trap_op = 0; in_slot = 0;
    @(negedge clk);
    chk("R9", "strobe single", 32'(take_exc), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule